// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers one-cycle event pulses from surrounding logic into a small set of sticky status bits. It drives a single active-low interrupt line to a host processor. Each sticky bit has a matching mask bit. A masked event is still recorded, but it cannot pull the interrupt line low. The host reads and clears the status through a simple register port. It also reads and writes the masks and reads the output-enable state.

The interrupt line starts disabled and idles high. Only a dedicated enable command strobe turns it on, and after that it stays enabled until reset. Status bit 15 is a live flag that follows a busy input, which comes from self-test or flush-reset logic. This bit can never be cleared or masked and never raises an interrupt. While it is set, the other status bits are hidden from reads and the interrupt line is held idle. The sticky state itself is kept, so it shows again once busy drops.

Top module: `irq_status_ctl`

## Requirements
- R1: Event inputs map to sticky status bits as follows: ev_proc_err to bit 10, ev_sync_loss to bit 11, a signal-detect change to bit 12, ev_flow_viol to bit 13 and ev_core_irq to bit 14. An event high at a rising clock edge makes its bit read 1 from that edge on, and the bit holds until it is cleared.
- R2: Bit 12 is set when any bit of sig_det differs from its value at the previous clock edge, whether it rises or falls. The remembered value is 0 after reset.
- R3: A host write to address 0 clears each of bits 14:10 where the write data holds 1 and leaves the others unchanged. If an event for the same bit arrives in the same cycle as its clear, the bit stays set.
- R4: The mask register is at address 1. Bits 14:10 are writable and all its other bits read 0. It resets to 0. A masked event still sets its status bit.
- R5: irq_n is 0 exactly when the output is enabled, busy is low, and some status bit in 14:10 is set with its mask bit clear. In every other case irq_n is 1.
- R6: After reset the output is disabled. A pulse on irq_en_cmd enables it from the next cycle on, and it stays enabled until reset. Address 2 reads the enable state in bit 0 and 0 in all other bits. Host writes to address 2 have no effect.
- R7: Status bit 15 reads the current value of busy. Writes cannot clear it and it never drives irq_n low.
- R8: While busy is high, a status read returns 16'h8000 and irq_n is 1. The sticky bits keep their values, and new events are still recorded.
- R9: Status bits 9:0 read 0, and address 3 reads 16'h0000.
- R10: rd_par gives odd parity over host_rdata, so the XOR of all 16 data bits and rd_par is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_proc_err | input | 1 | Processor-error event pulse |
| ev_sync_loss | input | 1 | Synchronisation-loss event pulse |
| ev_flow_viol | input | 1 | Flow-control violation event pulse |
| ev_core_irq | input | 1 | Embedded-core interrupt event pulse |
| sig_det | input | SD_W | Monitored signal-detect vector |
| busy | input | 1 | Self-test or flush reset running |
| irq_en_cmd | input | 1 | Command strobe that enables the interrupt output |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Register select: 0 status, 1 mask, 2 mode |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Combinational read data for host_addr |
| rd_par | output | 1 | Odd parity bit of host_rdata |
| irq_n | output | 1 | Active-low interrupt to the host |

## Verification
The assertions check on every cycle that:
- events set their bits and clear-versus-event conflicts resolve toward the event;
- a signal-detect change lands in bit 12;
- the enable never falls back;
- a disabled, busy or fully masked state keeps irq_n high;
- the read parity is odd.

Only the bench scenarios can show some other behaviour:
- the full match between the interrupt line and every combination of 32 status patterns against 32 masks;
- that mode writes are ignored;
- that hidden bits return after busy ends;
- that reserved bits and the unused address read 0.

// File: rtl/irq_status_ctl.sv
module irq_status_ctl #(
  parameter int SD_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_proc_err,
  input  logic            ev_sync_loss,
  input  logic            ev_flow_viol,
  input  logic            ev_core_irq,
  input  logic [SD_W-1:0] sig_det,
  input  logic            busy,
  input  logic            irq_en_cmd,
  input  logic            host_wr,
  input  logic [1:0]      host_addr,
  input  logic [15:0]     host_wdata,
  output logic [15:0]     host_rdata,
  output logic            rd_par,
  output logic            irq_n
);
  localparam int NEV = 5;
  localparam int LSB = 10;

  logic [NEV-1:0]  sticky, mask;
  logic            irq_en;
  logic [SD_W-1:0] sd_q;

  wire           sd_chg   = |(sig_det ^ sd_q);
  wire [NEV-1:0] ev       = {ev_core_irq, ev_flow_viol, sd_chg, ev_sync_loss, ev_proc_err};
  wire           wr_stat  = host_wr && host_addr == 2'd0;
  wire           wr_mask  = host_wr && host_addr == 2'd1;
  wire [NEV-1:0] clr      = wr_stat ? host_wdata[LSB+NEV-1:LSB] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky <= '0;
      mask   <= '0;
      irq_en <= 1'b0;
      sd_q   <= '0;
    end else begin
      sticky <= (sticky & ~clr) | ev;
      if (wr_mask) mask <= host_wdata[LSB+NEV-1:LSB];
      irq_en <= irq_en | irq_en_cmd;
      sd_q   <= sig_det;
    end
  end

  wire [15:0] status_view = busy ? 16'h8000 : {1'b0, sticky, {LSB{1'b0}}};

  always_comb begin
    case (host_addr)
      2'd0:    host_rdata = status_view;
      2'd1:    host_rdata = {1'b0, mask, {LSB{1'b0}}};
      2'd2:    host_rdata = {15'b0, irq_en};
      default: host_rdata = 16'h0000;
    endcase
  end

  assign rd_par = ~^host_rdata;
  assign irq_n  = ~(irq_en & ~busy & |(sticky & ~mask));
endmodule

// File: rtl/irq_status_ctl_chk.sv
module irq_status_ctl_chk #(
  parameter int SD_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ev_proc_err,
  input logic            ev_sync_loss,
  input logic            ev_core_irq,
  input logic [SD_W-1:0] sig_det,
  input logic            busy,
  input logic            host_wr,
  input logic [1:0]      host_addr,
  input logic [15:0]     host_wdata,
  input logic [15:0]     host_rdata,
  input logic            rd_par,
  input logic            irq_n,
  input logic [4:0]      sticky,
  input logic [4:0]      mask,
  input logic            irq_en
);
  a_r1_core_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_core_irq |=> sticky[4]);
  a_r2_sd_change: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_det != $past(sig_det)) |=> sticky[2]);
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd0 && host_wdata[10] && !ev_proc_err) |=> !sticky[0]);
  a_r3_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd0 && host_wdata[11] && ev_sync_loss) |=> sticky[1]);
  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((sticky & ~mask) == 5'd0) |-> irq_n);
  a_r5_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> irq_n);
  a_r6_en_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $past(irq_en) |-> irq_en);
  a_r7_busy_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> irq_n);
  a_r10_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (^{host_rdata, rd_par}) == 1'b1);
endmodule

bind irq_status_ctl irq_status_ctl_chk #(.SD_W(SD_W)) chk_i (.*);

// File: tb/irq_status_ctl_tb_top.sv
module irq_status_ctl_tb_top;
  localparam int SD_W = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_proc_err = 0, ev_sync_loss = 0, ev_flow_viol = 0, ev_core_irq = 0;
  logic [SD_W-1:0] sig_det = '0;
  logic busy = 0, irq_en_cmd = 0, host_wr = 0;
  logic [1:0] host_addr = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic rd_par, irq_n;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_status_ctl #(.SD_W(SD_W)) dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    ev_proc_err = 0; ev_sync_loss = 0; ev_flow_viol = 0; ev_core_irq = 0;
    host_wr = 0; irq_en_cmd = 0;
  endtask

  task automatic hwrite(logic [1:0] a, logic [15:0] d);
    host_wr = 1; host_addr = a; host_wdata = d; cyc();
  endtask

  task automatic fire(logic [4:0] s);
    ev_proc_err = s[0]; ev_sync_loss = s[1]; ev_flow_viol = s[3]; ev_core_irq = s[4];
    if (s[2]) sig_det = sig_det ^ 4'b0001;
    cyc();
  endtask

  task automatic rd(logic [1:0] a, string req, logic [15:0] exp);
    host_addr = a; #1;
    chk(req, host_rdata, exp);
    chk("R10", 32'(^{host_rdata, rd_par}), 1);
  endtask

  task automatic sweep(bit en);
    for (int m = 0; m < 32; m++) begin
      for (int s = 0; s < 32; s++) begin
        hwrite(0, 16'hFFFF);
        hwrite(1, 16'(m) << 10);
        fire(5'(s));
        rd(0, "R1", 16'(s) << 10);
        chk("R5", irq_n, !(en && ((s & ~m) != 0)));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, "R1", 16'h0000);
    rd(1, "R4", 16'h0000);
    rd(2, "R6", 16'h0000);
    chk("R5", irq_n, 1);
    sweep(0);
    hwrite(2, 16'hFFFF);
    rd(2, "R6", 16'h0000);
    irq_en_cmd = 1; cyc();
    rd(2, "R6", 16'h0001);
    hwrite(2, 16'h0000);
    rd(2, "R6", 16'h0001);
    sweep(1);
    hwrite(1, 16'hFFFF);
    rd(1, "R4", 16'h7C00);
    hwrite(1, 16'h0000);
    hwrite(0, 16'hFFFF);
    sig_det = 4'b1010; cyc();
    rd(0, "R2", 16'h1000);
    hwrite(0, 16'h1000);
    rd(0, "R3", 16'h0000);
    sig_det = 4'b0010; cyc();
    rd(0, "R2", 16'h1000);
    cyc();
    hwrite(0, 16'h1000);
    rd(0, "R2", 16'h0000);
    ev_sync_loss = 1; cyc();
    host_wr = 1; host_addr = 0; host_wdata = 16'h0800; ev_sync_loss = 1; cyc();
    rd(0, "R3", 16'h0800);
    ev_core_irq = 1; cyc();
    hwrite(0, 16'h0800);
    rd(0, "R3", 16'h4000);
    chk("R5", irq_n, 0);
    busy = 1; #1;
    rd(0, "R8", 16'h8000);
    chk("R7", irq_n, 1);
    hwrite(0, 16'hFFFF);
    rd(0, "R7", 16'h8000);
    ev_proc_err = 1; cyc();
    busy = 0; #1;
    rd(0, "R8", 16'h0400);
    chk("R5", irq_n, 0);
    rd(3, "R9", 16'h0000);
    hwrite(0, 16'hFFFF);
    rd(0, "R9", 16'h0000);
    chk("R5", irq_n, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule